// File: doc/BRIEF.md
# Folded Keccak-f[1600] Permutation Engine

This block applies the full 24-round Keccak-f[1600] permutation to a 1600-bit state. The state is held internally as 64 slices of 25 bits, and the datapath touches only a group of slices per clock. A load of the whole state enters in parallel when the engine is idle. After a fixed number of cycles the permuted state appears in parallel on the result port, and a one-cycle completion pulse marks it.

Each round is reordered to rotate, permute, apply the nonlinear step and add the round constant, then diffuse columns. The rotation step has no logic of its own: lanes are fetched from the slice store at offset addresses. The column-diffusion step runs as a separate pass. It carries the column parity of each group's last slice into the next group, and the first group wraps to slice 63. One diffusion pass is applied to the loaded state before round 0. None follows round 23, so the result equals the standard permutation.

There is no back-pressure. The engine accepts a load only while `busy` is low. The result stays on its port until the next completion overwrites it, so a consumer may pick it up at any time before then.

Top module: `keccak_slice_core`

## Requirements
- R1: While reset is asserted and after its release, `busy` and `done` are 0 and `result` is all zeros until the first completion.
- R2: A high `start` while `busy` is low captures `state_in`, and `busy` is 1 after that clock edge.
- R3: After the accepting edge, `busy` stays high for 48*(64/GRP) further edges (192 with GRP=16). It drops on the next edge, which is also the edge that raises `done`.
- R4: `done` is high for exactly one cycle per accepted load, and `busy` is low whenever `done` is high.
- R5: `result` equals Keccak-f[1600] (24 rounds) of the accepted state, with lane (x,y) bit z at bit position 64*(x+5*y)+z on both `state_in` and `result`.
- R6: For the all-zero input state, lane (0,0) of the result (bits 63:0) is 64'hF1258F7940E1DDE7.
- R7: `start` and `state_in` are ignored while `busy` is high. The run in progress keeps its timing and its result.
- R8: While `busy` is low, `result` holds the last computed state and changes only at a completion.
- R9: A `start` in the cycle where `done` is high is accepted, so loads may run back to back with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load request, honoured only while idle |
| state_in | input | 1600 | State to permute, lane (x,y) bit z at 64*(x+5*y)+z |
| busy | output | 1 | High from the accepting edge until the run completes |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | 1600 | Permuted state, same bit layout as `state_in` |

## Verification
The bench builds the engine with GRP=16, so each pass covers four slice groups. This exercises the carried column parity across three group boundaries and the wrap from slice 63 to slice 0. Many lane rotation offsets are not multiples of 16, so fetches that straddle two groups in the rotated read path are covered. A behavioural model tracks `busy` and `done` on every clock. It queues expected results from a plain lane-wise permutation. Vectors include all-zero, all-ones, single-bit, lane-patterned and random states, plus intrusive starts mid-run and back-to-back loads.

// File: rtl/kfold_pkg.sv
package kfold_pkg;
  localparam int LANE_W = 64;
  localparam int NLANE  = 25;
  localparam int NROUND = 24;
  localparam int STW    = LANE_W * NLANE;

  typedef logic [NLANE-1:0] slice_t;

  // Per-lane rotation amounts, 6 bits each, indexed by x+5*y.
  function automatic logic [NLANE*6-1:0] rho_table();
    logic [NLANE*6-1:0] t;
    int cx, cy, tmp;
    t  = '0;
    cx = 1;
    cy = 0;
    for (int k = 0; k < 24; k++) begin
      t[6*(cx+5*cy) +: 6] = 6'(((k + 1) * (k + 2) / 2) % LANE_W);
      tmp = cy;
      cy  = (2 * cx + 3 * cy) % 5;
      cx  = tmp;
    end
    return t;
  endfunction

  // All round constants, 64 bits per round, from the degree-8 LFSR.
  function automatic logic [NROUND*LANE_W-1:0] rc_table();
    logic [NROUND*LANE_W-1:0] t;
    logic [7:0] lf;
    logic       fb;
    t  = '0;
    lf = 8'h01;
    for (int s = 0; s < NROUND * 7; s++) begin
      if (lf[0]) t[LANE_W*(s/7) + (1 << (s % 7)) - 1] = 1'b1;
      fb = lf[7];
      lf = {lf[6:0], 1'b0};
      if (fb) lf = lf ^ 8'h71;
    end
    return t;
  endfunction

  // Column parity of one slice, one bit per x.
  function automatic logic [4:0] col_par(input slice_t s);
    logic [4:0] p;
    for (int x = 0; x < 5; x++) begin
      p[x] = s[x] ^ s[x+5] ^ s[x+10] ^ s[x+15] ^ s[x+20];
    end
    return p;
  endfunction
endpackage

// File: rtl/kf_theta_grp.sv
module kf_theta_grp
  import kfold_pkg::*;
#(
  parameter int GRP = 16
) (
  input  slice_t [GRP-1:0] din,
  input  logic   [4:0]     par_prev,
  output slice_t [GRP-1:0] dout,
  output logic   [4:0]     par_last
);
  logic [GRP-1:0][4:0] par;

  for (genvar j = 0; j < GRP; j++) begin : g_sl
    logic [4:0] prv;
    assign par[j] = col_par(din[j]);
    if (j == 0) begin : g_first
      assign prv = par_prev;
    end else begin : g_rest
      assign prv = par[j-1];
    end
    for (genvar x = 0; x < 5; x++) begin : g_x
      for (genvar y = 0; y < 5; y++) begin : g_y
        assign dout[j][x+5*y] = din[j][x+5*y] ^ par[j][(x+4)%5] ^ prv[(x+1)%5];
      end
    end
  end

  assign par_last = par[GRP-1];
endmodule

// File: rtl/kf_rho_fetch.sv
module kf_rho_fetch
  import kfold_pkg::*;
#(
  parameter int GRP = 16,
  parameter int GW  = 2
) (
  input  slice_t [LANE_W-1:0] bank,
  input  logic   [GW-1:0]     grp,
  output slice_t [GRP-1:0]    dout
);
  localparam logic [NLANE*6-1:0] OFFS = rho_table();
  localparam int ZW = $clog2(LANE_W);

  for (genvar j = 0; j < GRP; j++) begin : g_sl
    for (genvar i = 0; i < NLANE; i++) begin : g_ln
      localparam int OFF = int'(OFFS[6*i +: 6]);
      logic [ZW-1:0] src;
      // rotated lane bit z comes from stored slice z-OFF (mod lane width)
      assign src = ZW'(int'(grp) * GRP + j - OFF + LANE_W);
      assign dout[j][i] = bank[src][i];
    end
  end
endmodule

// File: rtl/kf_chi_grp.sv
module kf_chi_grp
  import kfold_pkg::*;
#(
  parameter int GRP = 16
) (
  input  slice_t [GRP-1:0] din,
  input  logic   [GRP-1:0] rc_bits,
  output slice_t [GRP-1:0] dout
);
  for (genvar j = 0; j < GRP; j++) begin : g_sl
    slice_t ps;
    for (genvar x = 0; x < 5; x++) begin : g_x
      for (genvar y = 0; y < 5; y++) begin : g_y
        localparam int L = x + 5 * y;
        assign ps[L] = din[j][(x + 3 * y) % 5 + 5 * x];
        if (L == 0) begin : g_iota
          assign dout[j][L] = ps[L] ^ (~ps[(x+1)%5 + 5*y] & ps[(x+2)%5 + 5*y]) ^ rc_bits[j];
        end else begin : g_plain
          assign dout[j][L] = ps[L] ^ (~ps[(x+1)%5 + 5*y] & ps[(x+2)%5 + 5*y]);
        end
      end
    end
  end
endmodule

// File: rtl/keccak_slice_core.sv
module keccak_slice_core
  import kfold_pkg::*;
#(
  parameter int GRP = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [STW-1:0] state_in,
  output logic           busy,
  output logic           done,
  output logic [STW-1:0] result
);
  localparam int NGRP = LANE_W / GRP;
  localparam int GW   = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam int ZW   = $clog2(LANE_W);
  localparam logic [GW-1:0] LASTG = GW'(NGRP - 1);
  localparam logic [NROUND*LANE_W-1:0] RC_T = rc_table();

  typedef enum logic [1:0] {S_IDLE, S_THETA, S_CHI, S_FIN} st_e;

  st_e                 st_q;
  logic [GW-1:0]       grp_q;
  logic [4:0]          rnd_q;
  logic                cur_q;
  logic [4:0]          carry_q;
  slice_t [LANE_W-1:0] bank_q [2];
  slice_t [LANE_W-1:0] cur_bank;

  slice_t [GRP-1:0] th_in, th_out, rho_out, chi_out;
  logic   [4:0]     par_prev, par_last;
  logic   [GRP-1:0] rc_bits;

  assign cur_bank = cur_q ? bank_q[1] : bank_q[0];
  assign busy     = (st_q != S_IDLE);

  always_comb begin
    for (int j = 0; j < GRP; j++) begin
      th_in[j] = cur_bank[ZW'(int'(grp_q) * GRP + j)];
    end
  end

  // group 0 wraps to the untouched last slice; later groups use the carry
  assign par_prev = (grp_q == '0) ? col_par(cur_bank[LANE_W-1]) : carry_q;
  assign rc_bits  = RC_T[int'(rnd_q) * LANE_W + int'(grp_q) * GRP +: GRP];

  kf_theta_grp #(.GRP(GRP)) u_theta (
    .din(th_in), .par_prev(par_prev), .dout(th_out), .par_last(par_last)
  );

  kf_rho_fetch #(.GRP(GRP), .GW(GW)) u_rho (
    .bank(cur_bank), .grp(grp_q), .dout(rho_out)
  );

  kf_chi_grp #(.GRP(GRP)) u_chi (
    .din(rho_out), .rc_bits(rc_bits), .dout(chi_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      grp_q   <= '0;
      rnd_q   <= '0;
      cur_q   <= 1'b0;
      carry_q <= '0;
      done    <= 1'b0;
      result  <= '0;
    end else begin
      done <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (start) begin
            st_q  <= S_THETA;
            grp_q <= '0;
            rnd_q <= '0;
            cur_q <= 1'b0;
          end
        end
        S_THETA: begin
          carry_q <= par_last;
          if (grp_q == LASTG) begin
            grp_q <= '0;
            st_q  <= S_CHI;
          end else begin
            grp_q <= grp_q + 1'b1;
          end
        end
        S_CHI: begin
          if (grp_q == LASTG) begin
            grp_q <= '0;
            cur_q <= ~cur_q;
            if (rnd_q == 5'(NROUND - 1)) begin
              st_q <= S_FIN;
            end else begin
              rnd_q <= rnd_q + 1'b1;
              st_q  <= S_THETA;
            end
          end else begin
            grp_q <= grp_q + 1'b1;
          end
        end
        default: begin
          st_q <= S_IDLE;
          done <= 1'b1;
          for (int z = 0; z < LANE_W; z++) begin
            for (int i = 0; i < NLANE; i++) begin
              result[LANE_W*i + z] <= cur_bank[z][i];
            end
          end
        end
      endcase
    end
  end

  // slice store: diffusion pass in place, nonlinear pass into the other bank
  always_ff @(posedge clk) begin
    if (st_q == S_IDLE && start) begin
      for (int z = 0; z < LANE_W; z++) begin
        for (int i = 0; i < NLANE; i++) begin
          bank_q[0][z][i] <= state_in[LANE_W*i + z];
        end
      end
    end else if (st_q == S_THETA) begin
      for (int j = 0; j < GRP; j++) begin
        bank_q[cur_q][ZW'(int'(grp_q) * GRP + j)] <= th_out[j];
      end
    end else if (st_q == S_CHI) begin
      for (int j = 0; j < GRP; j++) begin
        bank_q[~cur_q][ZW'(int'(grp_q) * GRP + j)] <= chi_out[j];
      end
    end
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(result));
  // R7
  run_keeps_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st_q != S_FIN) |=> busy);
  // R5
  pass_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_THETA && grp_q == LASTG) |=> (st_q == S_CHI && grp_q == '0));
  // R3
  round_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rnd_q < 5'(NROUND)));
endmodule

// File: tb/test_keccak_slice_core.sv
module test_keccak_slice_core;
  localparam int GRP   = 16;
  localparam int ITERS = (64 / GRP) * 48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1599:0] state_in = '0;
  logic          busy, done;
  logic [1599:0] result;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  keccak_slice_core #(.GRP(GRP)) i_keccak_slice_core (
    .clk(clk), .rst_n(rst_n), .start(start), .state_in(state_in),
    .busy(busy), .done(done), .result(result)
  );

  // ---------------- behavioural permutation ----------------
  function automatic logic [63:0] rotl(input logic [63:0] v, input int n);
    return (n == 0) ? v : ((v << n) | (v >> (64 - n)));
  endfunction

  function automatic int rot_amt(input int x, input int y);
    int a, b, t;
    a = 1; b = 0;
    if (x == 0 && y == 0) return 0;
    for (int k = 0; k < 24; k++) begin
      if (a == x && b == y) return ((k + 1) * (k + 2) / 2) % 64;
      t = b; b = (2 * a + 3 * b) % 5; a = t;
    end
    return 0;
  endfunction

  function automatic bit lfsr_bit(input int n);
    logic [7:0] r;
    r = 8'h01;
    for (int k = 0; k < n; k++) r = r[7] ? ({r[6:0], 1'b0} ^ 8'h71) : {r[6:0], 1'b0};
    return r[0];
  endfunction

  function automatic logic [1599:0] kref(input logic [1599:0] s);
    logic [63:0] a [25];
    logic [63:0] b [25];
    logic [63:0] c [5];
    logic [63:0] d [5];
    logic [63:0] rc;
    logic [1599:0] o;
    for (int i = 0; i < 25; i++) a[i] = s[64*i +: 64];
    for (int r = 0; r < 24; r++) begin
      for (int x = 0; x < 5; x++) c[x] = a[x] ^ a[x+5] ^ a[x+10] ^ a[x+15] ^ a[x+20];
      for (int x = 0; x < 5; x++) d[x] = c[(x+4)%5] ^ rotl(c[(x+1)%5], 1);
      for (int i = 0; i < 25; i++) a[i] = a[i] ^ d[i % 5];
      for (int x = 0; x < 5; x++)
        for (int y = 0; y < 5; y++)
          b[y + 5*((2*x + 3*y) % 5)] = rotl(a[x + 5*y], rot_amt(x, y));
      for (int x = 0; x < 5; x++)
        for (int y = 0; y < 5; y++)
          a[x + 5*y] = b[x + 5*y] ^ (~b[(x+1)%5 + 5*y] & b[(x+2)%5 + 5*y]);
      rc = '0;
      for (int j = 0; j < 7; j++) rc[(1 << j) - 1] = lfsr_bit(j + 7 * r);
      a[0] = a[0] ^ rc;
    end
    for (int i = 0; i < 25; i++) o[64*i +: 64] = a[i];
    return o;
  endfunction

  // ---------------- cycle model ----------------
  bit            m_busy = 0, m_done = 0, have_last = 0;
  int            cnt = 0;
  logic [1599:0] exp_q [$];
  logic [1599:0] last_exp = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; cnt = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start) begin
          m_busy = 1; cnt = 0;
          exp_q.push_back(kref(state_in));
        end
      end else begin
        cnt++;
        if (cnt == ITERS + 1) begin
          m_busy = 0; m_done = 1; have_last = 1;
          last_exp = exp_q.pop_front();
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [1599:0] act, input logic [1599:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(busy === m_busy, "R3 busy", 1600'(busy), 1600'(m_busy));
      chk(done === m_done, "R4 done", 1600'(done), 1600'(m_done));
      if (m_done) chk(result === last_exp, "R5 result", result, last_exp);
      else if (!m_busy && have_last) chk(result === last_exp, "R8 hold", result, last_exp);
    end
  end

  // ---------------- stimulus ----------------
  task automatic run_vec(input logic [1599:0] v, input bit intrude, input bit now);
    if (!now) @(negedge clk);
    state_in = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2 accept", 1600'(busy), 1600'(1));
    for (int k = 0; k < 50; k++) state_in[32*k +: 32] = $urandom();  // R7 input churn
    if (intrude) begin
      repeat (30) @(negedge clk);
      start = 1'b1;                                                   // R7 ignored start
      state_in = ~v;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    if (v == '0) chk(result[63:0] === 64'hF1258F7940E1DDE7, "R6 zero vector",
                     1600'(result[63:0]), 1600'(64'hF1258F7940E1DDE7));
  endtask

  initial begin
    logic [1599:0] v;
    repeat (3) @(negedge clk);
    // R1
    chk(busy === 1'b0 && done === 1'b0, "R1 in reset", 1600'({busy, done}), 1600'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && result === '0, "R1 after reset", result, '0);

    run_vec('0, 1'b0, 1'b0);
    v = '0;
    for (int i = 0; i < 25; i++) v[64*i +: 64] = {8{8'(i + 1)}};
    run_vec(v, 1'b1, 1'b0);
    run_vec({1600{1'b1}}, 1'b0, 1'b1);                                  // R9 back to back
    v = '0; v[1599] = 1'b1;
    run_vec(v, 1'b0, 1'b1);                                             // R9
    for (int n = 0; n < 3; n++) begin
      for (int k = 0; k < 50; k++) v[32*k +: 32] = $urandom();
      run_vec(v, n == 1, 1'b0);
    end
    start = 1'b0;
    repeat (20) @(negedge clk);                                          // R8 idle hold
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule